// File: doc/BRIEF.md
# Two-Phase Nibble Leading-One Detector

This block takes a 24-bit mantissa and returns the left-shift distance that would bring its highest set bit to bit 23, together with a flag for an all-zero mantissa. It sits between the add/subtract stage of a floating-point adder and the normalising shifter. The shifter and the exponent correction that use the count are outside this block.

Detection is split over two registered stages. The first stage views the mantissa as six 4-bit groups and builds a one-hot word marking the most significant group that holds a set bit. Each group gets a four-input OR, and the higher-group hits are combined in a shallow tree, so the logic stays within four gate levels of at most four inputs each. The second stage encodes that word into the upper three count bits. It takes the lower two count bits from the position of the highest set bit inside the selected group. The mantissa travels with its result, so the outputs present a mantissa next to its own count two cycles after it was accepted.

Top module: `lod_two_phase`

## Requirements
- R1: `out_valid` equals `in_valid` as sampled two rising edges earlier, for every cycle outside reset. Idle cycles pass through as idle cycles.
- R2: When `out_valid` is high, `out_mant` equals the `in_mant` that was accepted two rising edges earlier.
- R3: For a non-zero mantissa, `out_shift` equals the number of zero bits above its highest set bit. The count ranges from 0 (bit 23 set) to 23 (only bit 0 set).
- R4: For an all-zero mantissa, `out_zero` is 1 and `out_shift` is 0. For any non-zero mantissa, `out_zero` is 0.
- R5: For a non-zero result, shifting `out_mant` left by `out_shift` leaves a 1 in bit 23, and no set bit of `out_mant` lies above position 23 minus `out_shift`.
- R6: Group g covers bits 4g+3 down to 4g, with g from 0 to 5. If the highest set bit is in group g, then `out_shift[4:2]` equals 5 minus g. `out_shift[1:0]` counts the zero bits above that bit inside its group (0 when bit 4g+3 is set, 3 when bit 4g is set). The internal stage-one group word is one-hot exactly when its mantissa is non-zero, and all zero otherwise.
- R7: While `rst` is sampled high at a rising edge, the next cycle shows `out_valid`, `out_zero`, `out_shift` and `out_mant` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_mant` as a mantissa to process |
| in_mant | input | 24 | Mantissa to examine |
| out_valid | output | 1 | Marks the outputs as carrying a result |
| out_mant | output | 24 | The mantissa, delayed to line up with its count |
| out_shift | output | 5 | Left-shift distance that normalises `out_mant` |
| out_zero | output | 1 | High when `out_mant` has no set bit |

## Verification
The cases that are hardest to reach are those where the leading one sits deep in the low groups while every higher group is empty. In those cases the suppression term from the upper hits decides the result. Uniform random mantissas almost never produce them. The stimulus therefore walks a single set bit through all 24 positions. It also right-shifts random words by a random distance of up to 23, and it mixes in idle cycles between results so that a stale count or mantissa in either stage would show up.

// File: rtl/lod_pkg.sv
package lod_pkg;
    parameter int MANT_W = 24;
    parameter int NIB_W  = 4;

    localparam int NIBBLES = MANT_W / NIB_W;
    localparam int IDX_W   = $clog2(NIBBLES);
    localparam int POS_W   = $clog2(NIB_W);
    localparam int CNT_W   = IDX_W + POS_W;

    typedef struct packed {
        logic               valid;
        logic [MANT_W-1:0]  mant;
        logic [NIBBLES-1:0] word;
    } scan_stage_t;

    typedef struct packed {
        logic              valid;
        logic [MANT_W-1:0] mant;
        logic [CNT_W-1:0]  shift;
        logic              zero;
    } count_stage_t;

    typedef struct packed {
        scan_stage_t  scan;
        count_stage_t cnt;
    } lod_pipe_t;
endpackage

// File: rtl/lod_nibble_scan.sv
module lod_nibble_scan
    import lod_pkg::*;
(
    input  logic [MANT_W-1:0]  mant,
    output logic [NIBBLES-1:0] word
);
    logic [NIBBLES-1:0] hit;
    logic [NIBBLES-1:0] above;

    // level 1: one narrow OR per group
    for (genvar g = 0; g < NIBBLES; g++) begin : g_hit
        assign hit[g] = |mant[g*NIB_W +: NIB_W];
    end

    // levels 2-3: OR of all higher hits (at most five, a two-level tree)
    // level 4: keep this group only if nothing above it is set
    for (genvar g = 0; g < NIBBLES; g++) begin : g_word
        if (g == NIBBLES - 1) begin : g_top
            assign above[g] = 1'b0;
        end else begin : g_low
            assign above[g] = |hit[NIBBLES-1:g+1];
        end
        assign word[g] = hit[g] & ~above[g];
    end
endmodule

// File: rtl/lod_count_form.sv
module lod_count_form
    import lod_pkg::*;
(
    input  logic [MANT_W-1:0]  mant,
    input  logic [NIBBLES-1:0] word,
    output logic [CNT_W-1:0]   shift,
    output logic               zero
);
    logic [IDX_W-1:0] idx;
    logic [NIB_W-1:0] sel;
    logic [POS_W-1:0] pos;

    // one-hot word to group distance from the top, plus group mux
    always_comb begin
        idx = '0;
        sel = '0;
        for (int g = 0; g < NIBBLES; g++) begin
            if (word[g]) idx = idx | IDX_W'(NIBBLES - 1 - g);
            sel = sel | (mant[g*NIB_W +: NIB_W] & {NIB_W{word[g]}});
        end
    end

    // zero bits above the highest set bit inside the chosen group
    always_comb begin
        pos = '0;
        for (int b = 0; b < NIB_W; b++) begin
            if (sel[b]) pos = POS_W'(NIB_W - 1 - b);
        end
    end

    assign zero  = ~|word;
    assign shift = zero ? '0 : {idx, pos};
endmodule

// File: rtl/lod_two_phase.sv
module lod_two_phase
    import lod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [MANT_W-1:0] in_mant,
    output logic              out_valid,
    output logic [MANT_W-1:0] out_mant,
    output logic [CNT_W-1:0]  out_shift,
    output logic              out_zero
);
    lod_pipe_t pipe_d, pipe_q;

    logic [NIBBLES-1:0] scan_word;
    logic [CNT_W-1:0]   cnt_shift;
    logic               cnt_zero;

    lod_nibble_scan u_scan (
        .mant (in_mant),
        .word (scan_word)
    );

    lod_count_form u_form (
        .mant  (pipe_q.scan.mant),
        .word  (pipe_q.scan.word),
        .shift (cnt_shift),
        .zero  (cnt_zero)
    );

    always_comb begin
        pipe_d            = pipe_q;
        pipe_d.scan.valid = in_valid;
        pipe_d.scan.mant  = in_mant;
        pipe_d.scan.word  = scan_word;
        pipe_d.cnt.valid  = pipe_q.scan.valid;
        pipe_d.cnt.mant   = pipe_q.scan.mant;
        pipe_d.cnt.shift  = cnt_shift;
        pipe_d.cnt.zero   = cnt_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.cnt.valid;
    assign out_mant  = pipe_q.cnt.mant;
    assign out_shift = pipe_q.cnt.shift;
    assign out_zero  = pipe_q.cnt.zero;
endmodule

// File: rtl/lod_two_phase_chk.sv
module lod_two_phase_chk
    import lod_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [MANT_W-1:0]  in_mant,
    input logic               out_valid,
    input logic [MANT_W-1:0]  out_mant,
    input logic [CNT_W-1:0]   out_shift,
    input logic               out_zero,
    input logic [NIBBLES-1:0] scan_word_q,
    input logic [MANT_W-1:0]  scan_mant_q
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_valid_delay_r1: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_mant_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid) |-> (out_mant == $past(in_mant, 2)));

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_zero == (out_mant == '0)) && (!out_zero || out_shift == '0));

    p_normalised_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero) |->
            (((out_mant << out_shift) >> (MANT_W - 1)) == MANT_W'(1)));

    p_group_word_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(scan_word_q) && ((scan_word_q != '0) == (scan_mant_q != '0)));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_zero && out_shift == '0 && out_mant == '0));
endmodule

bind lod_two_phase lod_two_phase_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_mant     (in_mant),
    .out_valid   (out_valid),
    .out_mant    (out_mant),
    .out_shift   (out_shift),
    .out_zero    (out_zero),
    .scan_word_q (pipe_q.scan.word),
    .scan_mant_q (pipe_q.scan.mant)
);

// File: tb/lod_two_phase_tb.sv
module lod_two_phase_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_mant = '0;
    logic        out_valid;
    logic [23:0] out_mant;
    logic [4:0]  out_shift;
    logic        out_zero;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct { bit v; logic [23:0] m; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    lod_two_phase u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mant(in_mant),
        .out_valid(out_valid), .out_mant(out_mant),
        .out_shift(out_shift), .out_zero(out_zero)
    );

    function automatic int ref_msb(logic [23:0] m);
        int r = -1;
        for (int b = 0; b < 24; b++) if (m[b]) r = b;
        return r;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare();
        exp_t e = q.pop_front();
        chk(out_valid == e.v, "R1 valid", out_valid, e.v);
        if (e.v) begin
            int msb = ref_msb(e.m);
            chk(out_mant == e.m, "R2 mant", out_mant, e.m);
            if (msb < 0) begin
                chk(out_zero == 1'b1, "R4 zero flag", out_zero, 1);
                chk(out_shift == 5'd0, "R4 zero count", out_shift, 0);
            end else begin
                logic [23:0] sh;
                chk(out_zero == 1'b0, "R4 nonzero flag", out_zero, 0);
                chk(out_shift == 5'(23 - msb), "R3 count", out_shift, 23 - msb);
                chk(out_shift[4:2] == 3'(5 - msb / 4), "R6 group", out_shift[4:2], 5 - msb / 4);
                chk(out_shift[1:0] == 2'(3 - msb % 4), "R6 position", out_shift[1:0], 3 - msb % 4);
                sh = out_mant << out_shift;
                chk(sh[23] == 1'b1, "R5 normalised", sh[23], 1);
            end
        end
    endtask

    task automatic step(bit v, logic [23:0] m);
        @(negedge clk);
        compare();
        in_valid = v;
        in_mant  = m;
        q.push_back('{v, m});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: outputs cleared by reset
        chk(out_valid == 1'b0, "R7 valid", out_valid, 0);
        chk(out_zero == 1'b0, "R7 zero", out_zero, 0);
        chk(out_shift == 5'd0, "R7 shift", out_shift, 0);
        chk(out_mant == 24'd0, "R7 mant", out_mant, 0);
        rst = 1'b0;
        q.push_back('{1'b0, 24'd0});
        in_valid = 1'b1;
        in_mant  = 24'h800000;
        q.push_back('{1'b1, 24'h800000});

        for (int b = 0; b < 24; b++) step(1'b1, 24'd1 << b);       // R3 walk
        step(1'b1, 24'd0);                                         // R4
        step(1'b1, 24'hFFFFFF);
        step(1'b0, 24'h000001);                                    // R1 bubble
        step(1'b1, 24'd0);
        step(1'b1, 24'h000001);
        for (int b = 0; b < 24; b++) step(1'b1, (24'd1 << b) | 24'd1);
        for (int i = 0; i < 600; i++) begin
            logic [23:0] r = 24'($urandom);
            int s = $urandom_range(0, 23);
            bit v = ($urandom_range(0, 4) != 0);
            if ($urandom_range(0, 15) == 0) r = '0;
            step(v, r >> s);
        end
        step(1'b0, 24'd0);
        step(1'b0, 24'd0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule